// File: doc/BRIEF.md
# Banked Port Register Interface

This block is the byte-wide register front end of a 32-line digital input module. A host reaches it through a simple synchronous bus with a select, a write strobe, a 6-bit word address and 8-bit write and read data. Word addresses 0 to 7 form a window onto one bank of eight 8-bit ports. Words 8, 9 and 10 hold control registers that do not depend on the mode. All other words are empty.

After reset the block runs in standard mode. In this mode only the I/O bank shows through the window. Four ports show the live input lines, one byte each. A mask register decides which of those ports accept writes into their output latches. Setting the enhanced bit makes the bank select take effect. The window can then also show the event-sense configuration bank and the debounce configuration bank. Those configuration bytes are brought out as ports for neighbouring event and debounce logic. A software reset bit returns every bank register to its reset value without touching the control registers.

Top module: `pbr_regif`

## Requirements
- R1: After reset, bus_rdata, drv_latch, evt_cfg, dbn_en, dbn_time, irq_en and irq_vec are all zero. The mode register reads 0x00 (standard mode, bank 0) and the mask reads 0x0F.
- R2: A read (bus_sel=1, bus_we=0) sampled at a rising edge puts its data on bus_rdata after that edge. bus_rdata holds its value while no read is made.
- R3: In standard mode (mode bit 0 = 0) the window always shows bank 0, whatever the bank-select bits say. Window words 0 to 3 read the input lines, with word p returning in_lines[8p+7:8p].
- R4: These locations read 0x00 and ignore writes: window words 4 to 6 of bank 0, window words 5 to 7 of bank 2, every window word of bank 3, and all word addresses from 11 to 63.
- R5: Window word 7 of bank 0 is the mask. Bit p (p = 0 to 3) set to 1 blocks writes to input port p. Bits 7:4 read as 0, and the mask resets to 0x0F.
- R6: A write to input port p whose mask bit is 0 stores the byte in drv_latch[8p+7:8p]. Reads of that port still return the input lines.
- R7: Word 8 is the mode register. Bit 0 selects enhanced mode, bits 2:1 select the bank (0 = I/O, 1 = event, 2 = debounce, 3 = none), and bits 2:0 read back.
- R8: In enhanced mode, bank 1 holds eight read/write bytes. Window word p appears on evt_cfg[8p+7:8p].
- R9: In enhanced mode, bank 2 window words 0 to 3 are read/write bytes on dbn_en[8p+7:8p]. Window word 4 holds the 2-bit dbn_time in bits 1:0, and its other bits read 0.
- R10: In enhanced mode, bank 0 behaves exactly as it does in standard mode: the input reads, the mask, and the masked latch writes.
- R11: Word 9 bit 0 is the interrupt-request enable, shown on irq_en. Word 10 is an 8-bit read/write interrupt vector, shown on irq_vec.
- R12: Writing 1 to word 9 bit 1 returns the mask, drv_latch, evt_cfg, dbn_en and dbn_time to their reset values on the next rising edge. The mode, the interrupt enable and the vector are left as they are, and the bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | 1 = write, 0 = read while selected |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| in_lines | input | 32 | Input line levels |
| drv_latch | output | 32 | Output latches of the input ports |
| evt_cfg | output | 64 | Event-sense configuration bytes |
| dbn_en | output | 32 | Debounce enable bytes |
| dbn_time | output | 2 | Debounce time select |
| irq_en | output | 1 | Interrupt-request enable |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The assertions assume that in_lines and every bus input are synchronous to clk and stable around its rising edge. They also assume that rst_n is the only reset source. The bench drives all inputs on falling edges and keeps each access exactly one cycle long. It leaves one idle cycle after each software reset write, so the clear edge never coincides with a read the bench depends on. The assertions check a word 9 write only when it is not immediately followed by another word 9 write, and the bench never makes two such writes back to back.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int PORTS_PER_BANK = 8;
  localparam int PORT_IDX_W     = $clog2(PORTS_PER_BANK);

  localparam int WORD_MODE = 8;
  localparam int WORD_IRQ  = 9;
  localparam int WORD_VEC  = 10;

  localparam logic [1:0] BANK_IO  = 2'd0;
  localparam logic [1:0] BANK_EVT = 2'd1;
  localparam logic [1:0] BANK_DBN = 2'd2;

  localparam int MODE_ENH_BIT = 0;
  localparam int IRQ_EN_BIT   = 0;
  localparam int SWRST_BIT    = 1;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_INPORT,
    TGT_MASK,
    TGT_EVT,
    TGT_DBN_EN,
    TGT_DBN_TIME,
    TGT_MODE,
    TGT_IRQ,
    TGT_VEC
  } tgt_kind_e;

  typedef struct packed {
    tgt_kind_e             kind;
    logic [PORT_IDX_W-1:0] idx;
  } tgt_t;
endpackage

// File: rtl/pbr_addr_dec.sv
module pbr_addr_dec
  import pbr_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int IN_PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              enh_i,
  input  logic [1:0]        bank_i,
  output tgt_t              tgt_o
);
  localparam int DBN_TIME_PORT = IN_PORTS;
  localparam int MASK_PORT     = PORTS_PER_BANK - 1;

  logic                  in_window;
  logic [PORT_IDX_W-1:0] port;
  logic [1:0]            bank_eff;

  always_comb begin
    in_window = (addr_i[ADDR_W-1:PORT_IDX_W] == '0);
    port      = addr_i[PORT_IDX_W-1:0];
    bank_eff  = enh_i ? bank_i : BANK_IO;
    tgt_o.idx  = port;
    tgt_o.kind = TGT_NONE;
    if (in_window) begin
      unique case (bank_eff)
        BANK_IO: begin
          if (int'(port) < IN_PORTS)        tgt_o.kind = TGT_INPORT;
          else if (int'(port) == MASK_PORT) tgt_o.kind = TGT_MASK;
        end
        BANK_EVT: tgt_o.kind = TGT_EVT;
        BANK_DBN: begin
          if (int'(port) < IN_PORTS)            tgt_o.kind = TGT_DBN_EN;
          else if (int'(port) == DBN_TIME_PORT) tgt_o.kind = TGT_DBN_TIME;
        end
        default: tgt_o.kind = TGT_NONE;
      endcase
    end else if (addr_i == ADDR_W'(WORD_MODE)) begin
      tgt_o.kind = TGT_MODE;
    end else if (addr_i == ADDR_W'(WORD_IRQ)) begin
      tgt_o.kind = TGT_IRQ;
    end else if (addr_i == ADDR_W'(WORD_VEC)) begin
      tgt_o.kind = TGT_VEC;
    end
  end
endmodule

// File: rtl/pbr_ctrl_regs.sv
module pbr_ctrl_regs
  import pbr_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  tgt_t              tgt_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic              enh_o,
  output logic [1:0]        bank_o,
  output logic              irq_en_o,
  output logic              swrst_o,
  output logic [PORT_W-1:0] vec_o
);
  logic [2:0]        mode_q, mode_d;
  logic              mode_en;
  logic              irq_en_q, irq_en_d, irq_en_en;
  logic              swrst_q, swrst_d;
  logic [PORT_W-1:0] vec_q, vec_d;
  logic              vec_en;
  logic              wr_irq;

  always_comb begin
    wr_irq    = wr_i && (tgt_i.kind == TGT_IRQ);
    mode_en   = wr_i && (tgt_i.kind == TGT_MODE);
    mode_d    = wdata_i[2:0];
    irq_en_en = wr_irq;
    irq_en_d  = wdata_i[IRQ_EN_BIT];
    swrst_d   = wr_irq && wdata_i[SWRST_BIT];
    vec_en    = wr_i && (tgt_i.kind == TGT_VEC);
    vec_d     = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      irq_en_q <= 1'b0;
      swrst_q  <= 1'b0;
      vec_q    <= '0;
    end else begin
      if (mode_en)   mode_q   <= mode_d;
      if (irq_en_en) irq_en_q <= irq_en_d;
      swrst_q <= swrst_d;
      if (vec_en)    vec_q    <= vec_d;
    end
  end

  assign enh_o    = mode_q[MODE_ENH_BIT];
  assign bank_o   = mode_q[2:1];
  assign irq_en_o = irq_en_q;
  assign swrst_o  = swrst_q;
  assign vec_o    = vec_q;

  // R12: the reset bit produces a single pulse
  p_swrst_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && tgt_i.kind == TGT_IRQ && wdata_i[SWRST_BIT]) |=> swrst_o);
  p_swrst_selfclear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && tgt_i.kind == TGT_IRQ) |=> !swrst_o);
  // R11: the vector changes only on a write to its word
  p_vec_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && tgt_i.kind == TGT_VEC) |=> $stable(vec_o));
endmodule

// File: rtl/pbr_bank_store.sv
module pbr_bank_store
  import pbr_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int IN_PORTS   = 4,
  parameter int EVT_PORTS  = 8,
  parameter int DBN_TIME_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  tgt_t                          tgt_i,
  input  logic [PORT_W-1:0]             wdata_i,
  output logic [IN_PORTS-1:0]           mask_o,
  output logic [IN_PORTS*PORT_W-1:0]    drv_o,
  output logic [EVT_PORTS*PORT_W-1:0]   evt_o,
  output logic [IN_PORTS*PORT_W-1:0]    dbn_en_o,
  output logic [DBN_TIME_W-1:0]         dbn_time_o
);
  logic [IN_PORTS-1:0]   mask_q, mask_d;
  logic                  mask_en;
  logic [DBN_TIME_W-1:0] time_q, time_d;
  logic                  time_en;
  logic                  sel_blocked;

  always_comb begin
    mask_en = clr_i || (wr_i && tgt_i.kind == TGT_MASK);
    mask_d  = clr_i ? '1 : wdata_i[IN_PORTS-1:0];
    time_en = clr_i || (wr_i && tgt_i.kind == TGT_DBN_TIME);
    time_d  = clr_i ? '0 : wdata_i[DBN_TIME_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      time_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (time_en) time_q <= time_d;
    end
  end

  for (genvar p = 0; p < IN_PORTS; p++) begin : g_in
    logic [PORT_W-1:0] drv_q, drv_d, den_q, den_d;
    logic              drv_en, den_en;
    always_comb begin
      drv_en = clr_i || (wr_i && tgt_i.kind == TGT_INPORT &&
                         tgt_i.idx == PORT_IDX_W'(p) && !mask_q[p]);
      drv_d  = clr_i ? '0 : wdata_i;
      den_en = clr_i || (wr_i && tgt_i.kind == TGT_DBN_EN &&
                         tgt_i.idx == PORT_IDX_W'(p));
      den_d  = clr_i ? '0 : wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        drv_q <= '0;
        den_q <= '0;
      end else begin
        if (drv_en) drv_q <= drv_d;
        if (den_en) den_q <= den_d;
      end
    end
    assign drv_o[p*PORT_W +: PORT_W]    = drv_q;
    assign dbn_en_o[p*PORT_W +: PORT_W] = den_q;
  end

  for (genvar e = 0; e < EVT_PORTS; e++) begin : g_evt
    logic [PORT_W-1:0] evt_q, evt_d;
    logic              evt_en;
    always_comb begin
      evt_en = clr_i || (wr_i && tgt_i.kind == TGT_EVT &&
                         tgt_i.idx == PORT_IDX_W'(e));
      evt_d  = clr_i ? '0 : wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      evt_q <= '0;
      else if (evt_en) evt_q <= evt_d;
    end
    assign evt_o[e*PORT_W +: PORT_W] = evt_q;
  end

  assign mask_o     = mask_q;
  assign dbn_time_o = time_q;

  always_comb begin
    sel_blocked = 1'b0;
    for (int p = 0; p < IN_PORTS; p++)
      if (tgt_i.idx == PORT_IDX_W'(p)) sel_blocked = mask_q[p];
  end

  // R5: a masked port's latch does not change on a write
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && tgt_i.kind == TGT_INPORT && sel_blocked && !clr_i) |=> $stable(drv_o));
  // R12: the clear restores every bank register
  p_clear_restores_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (mask_o == '1 && drv_o == '0 && evt_o == '0 &&
               dbn_en_o == '0 && dbn_time_o == '0));
endmodule

// File: rtl/pbr_regif.sv
module pbr_regif
  import pbr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int PORT_W     = 8,
  parameter int NUM_IN     = 32,
  parameter int EVT_PORTS  = 8,
  parameter int DBN_TIME_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [PORT_W-1:0]             bus_wdata,
  output logic [PORT_W-1:0]             bus_rdata,
  input  logic [NUM_IN-1:0]             in_lines,
  output logic [NUM_IN-1:0]             drv_latch,
  output logic [EVT_PORTS*PORT_W-1:0]   evt_cfg,
  output logic [NUM_IN-1:0]             dbn_en,
  output logic [DBN_TIME_W-1:0]         dbn_time,
  output logic                          irq_en,
  output logic [PORT_W-1:0]             irq_vec
);
  localparam int IN_PORTS = NUM_IN / PORT_W;

  logic              rst_meta_n, rst_sync_n;
  logic              enh, swrst;
  logic [1:0]        bank;
  tgt_t              tgt;
  logic              wr, rd;
  logic [IN_PORTS-1:0] mask;
  logic [PORT_W-1:0] rdata_q, rdata_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  pbr_addr_dec #(.ADDR_W(ADDR_W), .IN_PORTS(IN_PORTS)) u_dec (
    .addr_i(bus_addr), .enh_i(enh), .bank_i(bank), .tgt_o(tgt)
  );

  pbr_ctrl_regs #(.PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(wr), .tgt_i(tgt), .wdata_i(bus_wdata),
    .enh_o(enh), .bank_o(bank), .irq_en_o(irq_en), .swrst_o(swrst), .vec_o(irq_vec)
  );

  pbr_bank_store #(
    .PORT_W(PORT_W), .IN_PORTS(IN_PORTS), .EVT_PORTS(EVT_PORTS), .DBN_TIME_W(DBN_TIME_W)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(swrst), .wr_i(wr), .tgt_i(tgt),
    .wdata_i(bus_wdata), .mask_o(mask), .drv_o(drv_latch), .evt_o(evt_cfg),
    .dbn_en_o(dbn_en), .dbn_time_o(dbn_time)
  );

  always_comb begin
    rdata_d = '0;
    unique case (tgt.kind)
      TGT_INPORT:
        for (int p = 0; p < IN_PORTS; p++)
          if (tgt.idx == PORT_IDX_W'(p)) rdata_d = in_lines[p*PORT_W +: PORT_W];
      TGT_MASK:     rdata_d = {{(PORT_W-IN_PORTS){1'b0}}, mask};
      TGT_EVT:
        for (int e = 0; e < EVT_PORTS; e++)
          if (tgt.idx == PORT_IDX_W'(e)) rdata_d = evt_cfg[e*PORT_W +: PORT_W];
      TGT_DBN_EN:
        for (int p = 0; p < IN_PORTS; p++)
          if (tgt.idx == PORT_IDX_W'(p)) rdata_d = dbn_en[p*PORT_W +: PORT_W];
      TGT_DBN_TIME: rdata_d = {{(PORT_W-DBN_TIME_W){1'b0}}, dbn_time};
      TGT_MODE:     rdata_d = {{(PORT_W-3){1'b0}}, bank, enh};
      TGT_IRQ:      rdata_d = {{(PORT_W-2){1'b0}}, swrst, irq_en};
      TGT_VEC:      rdata_d = irq_vec;
      default:      rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd)     rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R2: read data holds between reads
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd |=> $stable(bus_rdata));
  // R4: empty locations read as zero
  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd && tgt.kind == TGT_NONE) |=> (bus_rdata == '0));
  // R3: in standard mode the event bank cannot be written
  p_std_evt_stable_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!enh && !swrst) |=> $stable(evt_cfg));
endmodule

// File: tb/pbr_regif_bench.sv
module pbr_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [31:0] in_lines;
  logic [31:0] drv_latch;
  logic [63:0] evt_cfg;
  logic [31:0] dbn_en;
  logic [1:0]  dbn_time;
  logic        irq_en;
  logic [7:0]  irq_vec;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  pbr_regif u_pbr_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_lines(in_lines), .drv_latch(drv_latch), .evt_cfg(evt_cfg),
    .dbn_en(dbn_en), .dbn_time(dbn_time), .irq_en(irq_en), .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 drv", drv_latch, 0);
    chk("R1 evt", evt_cfg, 0);
    chk("R1 dbn_en", dbn_en, 0);
    chk("R1 dbn_time", dbn_time, 0);
    chk("R1 irq_en", irq_en, 0);
    chk("R1 vec", irq_vec, 0);
    rd(6'd8, d); chk("R1 mode", d, 8'h00);
    rd(6'd7, d); chk("R1 mask", d, 8'h0F);
  endtask

  task automatic t_inputs();
    logic [7:0] d;
    in_lines = 32'hA5C3_1E78;
    rd(6'd0, d); chk("R3 port0", d, 8'h78);
    rd(6'd1, d); chk("R3 port1", d, 8'h1E);
    rd(6'd2, d); chk("R3 port2", d, 8'hC3);
    rd(6'd3, d); chk("R3 port3", d, 8'hA5);
    in_lines = 32'h0123_4567;
    rd(6'd2, d); chk("R3 port2 new", d, 8'h23);
  endtask

  task automatic t_hold();
    rd(6'd3, bus_wdata);
    in_lines = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R2 hold", bus_rdata, 8'h01);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    rd(6'd4, d); chk("R4 word4", d, 0);
    wr(6'd5, 8'hFF);
    rd(6'd5, d); chk("R4 word5 write", d, 0);
    rd(6'd6, d); chk("R4 word6", d, 0);
    wr(6'd40, 8'h5A);
    rd(6'd40, d); chk("R4 word40", d, 0);
    rd(6'd11, d); chk("R4 word11", d, 0);
    rd(6'd63, d); chk("R4 word63", d, 0);
    chk("R4 no side effect", drv_latch, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(6'd1, 8'h5A);
    chk("R5 blocked at reset", drv_latch, 0);
    wr(6'd7, 8'hF0);
    rd(6'd7, d); chk("R5 upper bits", d, 8'h00);
    wr(6'd7, 8'h0D);
    rd(6'd7, d); chk("R5 mask readback", d, 8'h0D);
    wr(6'd1, 8'h5A);
    chk("R6 latch write", drv_latch, 32'h0000_5A00);
    wr(6'd0, 8'h11);
    chk("R5 port0 blocked", drv_latch, 32'h0000_5A00);
    in_lines = 32'h0000_C300;
    rd(6'd1, d); chk("R6 read shows lines", d, 8'hC3);
  endtask

  task automatic t_std_bank();
    logic [7:0] d;
    wr(6'd8, 8'h02);
    rd(6'd7, d); chk("R3 bank ignored mask", d, 8'h0D);
    wr(6'd1, 8'h33);
    chk("R3 bank ignored latch", drv_latch, 32'h0000_3300);
    chk("R3 evt untouched", evt_cfg, 0);
    rd(6'd8, d); chk("R7 mode readback", d, 8'h02);
  endtask

  task automatic t_evt();
    logic [7:0] d;
    wr(6'd8, 8'h03);
    for (int p = 0; p < 8; p++) wr(6'(p), 8'(16 + p));
    chk("R8 evt_cfg", evt_cfg, 64'h1716_1514_1312_1110);
    rd(6'd5, d); chk("R8 evt read", d, 8'h15);
  endtask

  task automatic t_dbn();
    logic [7:0] d;
    wr(6'd8, 8'h05);
    for (int p = 0; p < 4; p++) wr(6'(p), 8'(224 + p));
    chk("R9 dbn_en", dbn_en, 32'hE3E2_E1E0);
    wr(6'd4, 8'hFF);
    rd(6'd4, d); chk("R9 time read", d, 8'h03);
    chk("R9 dbn_time", dbn_time, 2'd3);
    wr(6'd6, 8'hFF);
    rd(6'd6, d); chk("R4 bank2 word6", d, 0);
    chk("R4 bank2 no effect", dbn_en, 32'hE3E2_E1E0);
  endtask

  task automatic t_bank3();
    logic [7:0] d;
    wr(6'd8, 8'h07);
    rd(6'd0, d); chk("R4 bank3 word0", d, 0);
    rd(6'd7, d); chk("R4 bank3 word7", d, 0);
    wr(6'd0, 8'h99);
    chk("R4 bank3 evt", evt_cfg, 64'h1716_1514_1312_1110);
    chk("R4 bank3 drv", drv_latch, 32'h0000_3300);
  endtask

  task automatic t_enh0();
    logic [7:0] d;
    wr(6'd8, 8'h01);
    in_lines = 32'hDEAD_BEEF;
    rd(6'd3, d); chk("R10 port3", d, 8'hDE);
    rd(6'd7, d); chk("R10 mask", d, 8'h0D);
    wr(6'd1, 8'h44);
    chk("R10 latch write", drv_latch, 32'h0000_4400);
    wr(6'd2, 8'h44);
    chk("R10 masked port", drv_latch, 32'h0000_4400);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(6'd9, 8'h01);
    chk("R11 irq_en", irq_en, 1);
    rd(6'd9, d); chk("R11 irq read", d, 8'h01);
    wr(6'd10, 8'hC7);
    chk("R11 vec", irq_vec, 8'hC7);
    rd(6'd10, d); chk("R11 vec read", d, 8'hC7);
  endtask

  task automatic t_swrst();
    logic [7:0] d;
    wr(6'd10, 8'h3C);
    wr(6'd8, 8'h00);
    wr(6'd7, 8'h0E);
    wr(6'd0, 8'h77);
    chk("R12 setup", drv_latch, 32'h0000_4477);
    wr(6'd9, 8'h03);
    @(negedge clk);
    chk("R12 drv", drv_latch, 0);
    chk("R12 evt", evt_cfg, 0);
    chk("R12 dbn_en", dbn_en, 0);
    chk("R12 dbn_time", dbn_time, 0);
    chk("R12 irq kept", irq_en, 1);
    chk("R12 vec kept", irq_vec, 8'h3C);
    rd(6'd7, d); chk("R12 mask", d, 8'h0F);
    rd(6'd9, d); chk("R12 bit reads 0", d, 8'h01);
    wr(6'd8, 8'h01);
    rd(6'd8, d); chk("R12 mode kept", d, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; in_lines = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_inputs();
    t_hold();
    t_unused();
    t_mask();
    t_std_bank();
    t_evt();
    t_dbn();
    t_bank3();
    t_enh0();
    t_irq();
    t_swrst();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule